// File: doc/BRIEF.md
# Data Rate Clock Selector

This block produces the bit-cell timing strobe for one floppy disk channel. The host picks one of four data rates by writing a 2-bit rate code. The code is latched when the register-select strobe and the write strobe are both high. Three of the rates come from dividing the 16 MHz reference. The fourth rate comes from dividing a 9.6 MHz reference. Both references reach the block as clock-enable pulses inside a single 16 MHz system clock domain. The output is a one-cycle strobe per bit cell.

A drive-type input says whether the attached drive has a two-speed spindle. When it does (drive type low), the 9.6 MHz reference is never used. In that case the 300 kbit/s code falls back to 250 kbit/s from the 16 MHz reference. The block also reports the write precompensation delay, in reference-clock cycles, that matches the precompensation value pin. The write path uses this delay to shift inner-track data. That shift is done outside this block.

Top module: `rate_clk_sel`

## Requirements
- R1: When `cfg_ld` and `host_wr` are both 1 on a clock edge, `rate_code` takes `host_data[1:0]` after that edge. In every other cycle `rate_code` keeps its value, whatever `host_data` holds.
- R2: While `rst_n` is low, `rate_code` is 00, `bit_strobe` is 0 and the divider count is zero.
- R3: Code 00 (500 kbit/s) gives one `bit_strobe` for every 32 cycles in which `ref16_en` is 1.
- R4: Code 10 (250 kbit/s) gives one strobe per 64 `ref16_en` pulses. Code 11 (125 kbit/s) gives one strobe per 128 `ref16_en` pulses.
- R5: Code 01 with `drive_type` = 1 (300 kbit/s) gives one strobe per 32 `ref96_en` pulses. `ref16_en` has no effect in this mode, and `alt_active` is 1.
- R6: Code 01 with `drive_type` = 0 gives one strobe per 64 `ref16_en` pulses. `ref96_en` has no effect in this mode, and `alt_active` is 0. `alt_active` is 0 whenever `drive_type` is 0.
- R7: `bit_strobe` is registered. It is high for exactly one cycle: the cycle after the clock edge at which the counted enable completes the division. It is never high in two consecutive cycles.
- R8: A change of the effective selection (source or divisor, caused by `rate_code` or `drive_type`) clears the count on the next edge without a strobe. Counting then restarts from zero.
- R9: `precomp_cyc` is 2 when `precomp_val` is 1 (125 ns) and 3 when `precomp_val` is 0 (187 ns).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref16_en | input | 1 | Clock enable standing for the 16 MHz reference |
| ref96_en | input | 1 | Clock enable standing for the 9.6 MHz reference |
| cfg_ld | input | 1 | Register-select strobe for the rate code |
| host_wr | input | 1 | Host write strobe |
| host_data | input | 2 | Rate code from the host bus |
| drive_type | input | 1 | 0 = two-speed spindle, which forbids the 9.6 MHz reference |
| precomp_val | input | 1 | Precompensation value select |
| rate_code | output | 2 | Latched rate code |
| alt_active | output | 1 | 1 when the 9.6 MHz reference drives the divider |
| bit_strobe | output | 1 | One-cycle bit-cell strobe |
| precomp_cyc | output | 2 | Precompensation delay in reference cycles |

## Verification
The hardest case to reach is a change of selection partway through a count. Examples are `drive_type` toggling while code 01 is held, or a new code landing while enables are arriving. To hit these, the stimulus switches selections at random cycles during dense enable traffic. It also drives both reference enables at the same time, so the unused source is always active. A behavioural model counts enables for the selected source on every clock. It compares each cycle's strobe, code, source flag and precompensation output. Quiet, isolated phases also tally strobes against the enable count.

// File: rtl/rate_clk_pkg.sv
package rate_clk_pkg;

    typedef enum logic [1:0] {
        RATE_500 = 2'b00,
        RATE_300 = 2'b01,
        RATE_250 = 2'b10,
        RATE_125 = 2'b11
    } rate_code_e;

    typedef enum logic [1:0] {
        SCALE_X1 = 2'd0,
        SCALE_X2 = 2'd1,
        SCALE_X4 = 2'd2
    } div_scale_e;

    typedef struct packed {
        logic       use_alt;
        div_scale_e scale;
    } cell_sel_t;

    localparam cell_sel_t SEL_RESET = '{use_alt: 1'b0, scale: SCALE_X1};

endpackage

// File: rtl/rate_latch.sv
module rate_latch
    import rate_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  logic       wr,
    input  logic [1:0] din,
    output rate_code_e code
);

    typedef struct packed {
        rate_code_e code;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld && wr) begin
            st_d.code = rate_code_e'(din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= RATE_500;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;

endmodule

// File: rtl/rate_decode.sv
module rate_decode
    import rate_clk_pkg::*;
(
    input  rate_code_e code,
    input  logic       drive_type,
    output cell_sel_t  sel
);

    always_comb begin
        sel = SEL_RESET;
        unique case (code)
            RATE_500: sel = '{use_alt: 1'b0, scale: SCALE_X1};
            RATE_300: begin
                if (drive_type) begin
                    sel = '{use_alt: 1'b1, scale: SCALE_X1};
                end else begin
                    sel = '{use_alt: 1'b0, scale: SCALE_X2};
                end
            end
            RATE_250: sel = '{use_alt: 1'b0, scale: SCALE_X2};
            RATE_125: sel = '{use_alt: 1'b0, scale: SCALE_X4};
            default:  sel = SEL_RESET;
        endcase
    end

endmodule

// File: rtl/cell_divider.sv
module cell_divider
    import rate_clk_pkg::*;
#(
    parameter int BASE_DIV = 32,
    parameter int ALT_DIV  = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  cell_sel_t sel,
    input  logic      ref16_en,
    input  logic      ref96_en,
    output logic      strobe
);

    localparam int MAX_DIV = (4 * BASE_DIV > ALT_DIV) ? 4 * BASE_DIV : ALT_DIV;
    localparam int CNT_W   = $clog2(MAX_DIV);

    typedef struct packed {
        cell_sel_t          sel;
        logic [CNT_W-1:0]   cnt;
        logic               strobe;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    src_en;

    function automatic logic [CNT_W-1:0] last_of(cell_sel_t s);
        int d;
        if (s.use_alt) begin
            d = ALT_DIV;
        end else begin
            case (s.scale)
                SCALE_X1: d = BASE_DIV;
                SCALE_X2: d = 2 * BASE_DIV;
                default:  d = 4 * BASE_DIV;
            endcase
        end
        return CNT_W'(d - 1);
    endfunction

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        src_en      = sel.use_alt ? ref96_en : ref16_en;
        if (sel != st_q.sel) begin
            st_d.sel = sel;
            st_d.cnt = '0;
        end else if (src_en) begin
            if (st_q.cnt == last_of(st_q.sel)) begin
                st_d.cnt    = '0;
                st_d.strobe = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel    <= SEL_RESET;
            st_q.cnt    <= '0;
            st_q.strobe <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = st_q.strobe;

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last_of(st_q.sel));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != st_q.sel) |=> (st_q.cnt == '0 && !st_q.strobe));

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |=> !st_q.strobe);

endmodule

// File: rtl/precomp_pick.sv
module precomp_pick #(
    parameter int PRE_SHORT = 2,
    parameter int PRE_LONG  = 3,
    parameter int PRE_W     = 2
) (
    input  logic             val,
    output logic [PRE_W-1:0] cyc
);

    always_comb begin
        cyc = val ? PRE_W'(PRE_SHORT) : PRE_W'(PRE_LONG);
    end

endmodule

// File: rtl/rate_clk_sel.sv
module rate_clk_sel
    import rate_clk_pkg::*;
#(
    parameter int BASE_DIV  = 32,
    parameter int ALT_DIV   = 32,
    parameter int PRE_SHORT = 2,
    parameter int PRE_LONG  = 3,
    parameter int PRE_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref16_en,
    input  logic             ref96_en,
    input  logic             cfg_ld,
    input  logic             host_wr,
    input  logic [1:0]       host_data,
    input  logic             drive_type,
    input  logic             precomp_val,
    output logic [1:0]       rate_code,
    output logic             alt_active,
    output logic             bit_strobe,
    output logic [PRE_W-1:0] precomp_cyc
);

    rate_code_e code;
    cell_sel_t  sel;

    rate_latch i_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .ld   (cfg_ld),
        .wr   (host_wr),
        .din  (host_data),
        .code (code)
    );

    rate_decode i_decode (
        .code      (code),
        .drive_type(drive_type),
        .sel       (sel)
    );

    cell_divider #(
        .BASE_DIV(BASE_DIV),
        .ALT_DIV (ALT_DIV)
    ) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .ref16_en(ref16_en),
        .ref96_en(ref96_en),
        .strobe  (bit_strobe)
    );

    precomp_pick #(
        .PRE_SHORT(PRE_SHORT),
        .PRE_LONG (PRE_LONG),
        .PRE_W    (PRE_W)
    ) i_pre (
        .val(precomp_val),
        .cyc(precomp_cyc)
    );

    assign rate_code  = code;
    assign alt_active = sel.use_alt;

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ld && host_wr) |=> (rate_code == $past(host_data)));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_ld && host_wr) |=> $stable(rate_code));

    p_alt_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_type |-> !alt_active);

    p_precomp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        precomp_val |-> (precomp_cyc == PRE_W'(PRE_SHORT)));

endmodule

// File: tb/test_rate_clk_sel.sv
module test_rate_clk_sel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref16_en = 1'b0;
    logic       ref96_en = 1'b0;
    logic       cfg_ld = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_data = 2'b00;
    logic       drive_type = 1'b1;
    logic       precomp_val = 1'b0;
    logic [1:0] rate_code;
    logic       alt_active;
    logic       bit_strobe;
    logic [1:0] precomp_cyc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_rate = 0;
    int m_alt_sel = 0;
    int m_div_sel = 32;
    int m_cnt = 0;
    bit m_strobe = 1'b0;

    // phase tallies
    int en_tally = 0;
    int st_tally = 0;
    bit tally_alt = 1'b0;

    always #10 clk = ~clk;

    rate_clk_sel i_rate_clk_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref16_en   (ref16_en),
        .ref96_en   (ref96_en),
        .cfg_ld     (cfg_ld),
        .host_wr    (host_wr),
        .host_data  (host_data),
        .drive_type (drive_type),
        .precomp_val(precomp_val),
        .rate_code  (rate_code),
        .alt_active (alt_active),
        .bit_strobe (bit_strobe),
        .precomp_cyc(precomp_cyc)
    );

    function automatic int exp_alt(int r, bit dt);
        return (r == 1 && dt) ? 1 : 0;
    endfunction

    function automatic int exp_div(int r, bit dt);
        case (r)
            0: return 32;
            1: return dt ? 32 : 64;
            2: return 64;
            default: return 128;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rate = 0; m_alt_sel = 0; m_div_sel = 32; m_cnt = 0; m_strobe = 1'b0;
        end else begin
            int a, d;
            bit en;
            a = exp_alt(m_rate, drive_type);
            d = exp_div(m_rate, drive_type);
            en = (a == 1) ? ref96_en : ref16_en;
            m_strobe = 1'b0;
            if (a != m_alt_sel || d != m_div_sel) begin
                m_alt_sel = a; m_div_sel = d; m_cnt = 0;
            end else if (en) begin
                if (m_cnt == d - 1) begin
                    m_cnt = 0; m_strobe = 1'b1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (cfg_ld && host_wr) m_rate = int'(host_data);
            if (tally_alt ? ref96_en : ref16_en) en_tally++;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(bit_strobe == m_strobe, "R7 strobe", int'(bit_strobe), int'(m_strobe));
            check(int'(rate_code) == m_rate, "R1 rate_code", int'(rate_code), m_rate);
            check(int'(alt_active) == exp_alt(m_rate, drive_type), "R5/R6 alt_active",
                  int'(alt_active), exp_alt(m_rate, drive_type));
            check(int'(precomp_cyc) == (precomp_val ? 2 : 3), "R9 precomp",
                  int'(precomp_cyc), precomp_val ? 2 : 3);
            if (bit_strobe) st_tally++;
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic load_code(int c, bit wr);
        cfg_ld = 1'b1; host_wr = wr; host_data = 2'(c);
        step();
        cfg_ld = 1'b0; host_wr = 1'b0; host_data = 2'(~c);
    endtask

    // isolated phase: count enables of the selected source, compare strobes
    task automatic phase(int c, bit dt, int n, int p16, int p96, bit alt, int div, string req);
        ref16_en = 1'b0; ref96_en = 1'b0;
        drive_type = dt;
        load_code(c, 1'b1);
        repeat (3) step();
        tally_alt = alt; en_tally = 0; st_tally = 0;
        for (int i = 0; i < n; i++) begin
            ref16_en = (($urandom % 100) < p16);
            ref96_en = (($urandom % 100) < p96);
            precomp_val = $urandom % 2;
            step();
        end
        ref16_en = 1'b0; ref96_en = 1'b0;
        repeat (3) step();
        check(st_tally == en_tally / div, req, st_tally, en_tally / div);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R2: reset state
        check(rate_code == 2'b00, "R2 reset code", int'(rate_code), 0);
        check(bit_strobe == 1'b0, "R2 reset strobe", int'(bit_strobe), 0);
        ref16_en = 1'b1;
        repeat (40) step();
        check(bit_strobe == 1'b0, "R2 held in reset", int'(bit_strobe), 0);
        rst_n = 1'b1;
        step();

        phase(0, 1'b1, 1000, 100, 50, 1'b0, 32, "R3 div32");
        phase(0, 1'b0, 2000, 40, 90, 1'b0, 32, "R3 div32 sparse");
        phase(2, 1'b1, 3000, 70, 70, 1'b0, 64, "R4 div64");
        phase(3, 1'b1, 5000, 80, 80, 1'b0, 128, "R4 div128");
        phase(1, 1'b1, 4000, 90, 60, 1'b1, 32, "R5 alt div32");
        phase(1, 1'b0, 4000, 60, 95, 1'b0, 64, "R6 fallback div64");

        // R1: load with write low is ignored
        load_code(3, 1'b0);
        step();
        check(rate_code == 2'b01, "R1 ignored load", int'(rate_code), 1);
        cfg_ld = 1'b0; host_wr = 1'b1; host_data = 2'b11;
        step();
        host_wr = 1'b0;
        step();
        check(rate_code == 2'b01, "R1 wr without ld", int'(rate_code), 1);

        // R8: selection changes in mid count under dense traffic
        for (int i = 0; i < 20000; i++) begin
            ref16_en = (($urandom % 100) < 85);
            ref96_en = (($urandom % 100) < 85);
            precomp_val = $urandom % 2;
            if (($urandom % 300) == 0) drive_type = ~drive_type;
            if (($urandom % 400) == 0) begin
                cfg_ld = 1'b1;
                host_wr = $urandom % 2;
                host_data = 2'($urandom % 4);
            end else begin
                cfg_ld = 1'b0;
                host_wr = $urandom % 2;
                host_data = 2'($urandom % 4);
            end
            step();
        end
        cfg_ld = 1'b0; host_wr = 1'b0;
        step();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule